// File: doc/BRIEF.md
# CAN Overload Frame Sequencer

This block follows a CAN node through the period between frames, one bit at a time. A single-cycle bit strobe marks each bit. On that strobe the block samples the received bus level and chooses the transmit level for the next bit. The frame receiver pulses `eof_begin` when the end-of-frame field starts. It pulses `errdl_begin` when an error delimiter starts. From then on the sequencer counts the end-of-frame bits, the intermission bits and the delimiter bits itself.

An overload frame starts when the bus is dominant at one of these points:
- the first or second intermission bit;
- the last end-of-frame bit;
- the last delimiter bit.

It also starts when the local receiver is still busy as an intermission begins. The overload frame is a flag of dominant bits followed by a recessive delimiter. Other nodes may hold the bus dominant after this node's own flag. The sequencer waits through those bits before it counts the delimiter.

The block reports an overload frame in progress on `ovl_busy`. It reports a quiet bus on `bus_quiet`. It flags a start-of-frame seen at the end of intermission on `sof_seen`.

Top module: `can_ovl_seq`

## Requirements
- R1: After a synchronous reset, `tx_lvl` is 1 (recessive), `bus_quiet` is 1, and `ovl_busy` and `sof_seen` are 0. Dominant is 0 and recessive is 1 on both `rx_lvl` and `tx_lvl`.
- R2: Once an overload frame starts, `tx_lvl` is 0 for exactly 6 bits, starting with the bit after the trigger. `ovl_busy` is 1 throughout those 6 bits.
- R3: After its flag, the node drives recessive. It waits through any number of dominant bits from other nodes. The first recessive bit it samples counts as delimiter bit 1. Seven further bits complete the 8-bit delimiter. If the eighth bit is recessive, intermission follows.
- R4: A dominant level sampled on intermission bit 1 or bit 2 starts an overload frame.
- R5: A dominant level sampled on intermission bit 3, or on any bit while the bus is quiet, is treated as start-of-frame. `sof_seen` is 1 for the next bit time, `bus_quiet` drops to 0, and no overload frame starts.
- R6: A dominant level sampled on end-of-frame bit 7 starts an overload frame. Dominant levels on end-of-frame bits 1 to 6 do not start one.
- R7: A dominant level sampled on bit 8 of an error delimiter or of an overload delimiter starts a new overload flag on the very next bit.
- R8: If `rx_wait` is 1 when the last end-of-frame bit or the last delimiter bit is recessive, the intermission is replaced by an overload frame. At most 2 consecutive overload frames are caused this way. The count clears when an intermission completes or a start-of-frame is seen.
- R9: Outputs change only on clock edges where `bit_stb` is 1.
- R10: Three recessive intermission bits bring `bus_quiet` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| rx_lvl | input | 1 | Sampled bus level (0 dominant) |
| eof_begin | input | 1 | Pulse on the strobe before end-of-frame bit 1 |
| errdl_begin | input | 1 | Pulse on the strobe before error delimiter bit 1 |
| rx_wait | input | 1 | Receiver not ready; requests an overload frame |
| tx_lvl | output | 1 | Level driven for the next bit (0 dominant) |
| ovl_busy | output | 1 | Overload frame in progress |
| bus_quiet | output | 1 | Bus idle |
| sof_seen | output | 1 | Start-of-frame detected in the last sampled bit |

## Verification
The bench targets the bit positions where an off-by-one error changes the outcome. Examples are dominant on end-of-frame bit 6 versus bit 7, and dominant on intermission bit 2 versus bit 3. A design with a misplaced trigger would either start an overload frame on a frame start or miss a required one. Superimposed flags of several bits check that the delimiter count starts only at the first recessive bit; a design that counted from its own flag end would close the delimiter early. Back-to-back receiver-busy requests check the limit of two: a design without the limit would stall the bus in endless overload frames. Random traffic with strobe gaps checks that no output moves between strobes.

// File: rtl/ovlseq_pkg.sv
package ovlseq_pkg;
  typedef enum logic [2:0] {
    ST_QUIET, ST_FRAME, ST_EOF, ST_INTER, ST_FLAG, ST_HOLD, ST_DELIM
  } seq_st_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ovl_bitcnt.sv
module ovl_bitcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (stb) begin
      if (load)        cnt <= load_val;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ovl_req_gate.sv
module ovl_req_gate #(
  parameter int MAX_REQ = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic take,
  input  logic clr,
  output logic allow
);
  localparam int RW = $clog2(MAX_REQ + 1);
  logic [RW-1:0] used;

  always_ff @(posedge clk) begin
    if (rst)                    used <= '0;
    else if (stb) begin
      if (clr)                  used <= '0;
      else if (take && allow)   used <= used + 1'b1;
    end
  end

  assign allow = (used < RW'(MAX_REQ));

  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    stb && take && !clr |-> allow); // R8
endmodule

// File: rtl/can_ovl_seq.sv
module can_ovl_seq
  import ovlseq_pkg::*;
#(
  parameter int FLAG_BITS  = 6,
  parameter int DELIM_BITS = 8,
  parameter int EOF_BITS   = 7,
  parameter int INTER_BITS = 3,
  parameter int MAX_REQ    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic rx_lvl,
  input  logic eof_begin,
  input  logic errdl_begin,
  input  logic rx_wait,
  output logic tx_lvl,
  output logic ovl_busy,
  output logic bus_quiet,
  output logic sof_seen
);
  localparam int MAXB = imax(imax(FLAG_BITS, DELIM_BITS), imax(EOF_BITS, INTER_BITS));
  localparam int CW   = $clog2(MAXB + 1);
  localparam logic [CW-1:0] EOF_LAST   = CW'(EOF_BITS - 1);
  localparam logic [CW-1:0] INTER_LAST = CW'(INTER_BITS - 1);
  localparam logic [CW-1:0] FLAG_LAST  = CW'(FLAG_BITS - 1);
  localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 1);

  seq_st_t       st, nxt;
  logic [CW-1:0] cnt, load_val;
  logic          cnt_load, ovl_q, nxt_ovl;
  logic          take, clr_req, allow, sof_n;
  logic          go_inter, go_ovl;

  ovl_bitcnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .stb(bit_stb),
    .load(cnt_load), .load_val(load_val), .cnt(cnt)
  );

  ovl_req_gate #(.MAX_REQ(MAX_REQ)) u_req (
    .clk(clk), .rst(rst), .stb(bit_stb),
    .take(take), .clr(clr_req), .allow(allow)
  );

  always_comb begin
    nxt      = st;
    cnt_load = 1'b0;
    load_val = '0;
    nxt_ovl  = ovl_q;
    take     = 1'b0;
    clr_req  = 1'b0;
    sof_n    = 1'b0;
    go_inter = 1'b0;
    go_ovl   = 1'b0;
    if (eof_begin) begin
      nxt = ST_EOF; cnt_load = 1'b1;
    end else if (errdl_begin) begin
      nxt = ST_DELIM; cnt_load = 1'b1; nxt_ovl = 1'b0;
    end else begin
      unique case (st)
        ST_QUIET: if (!rx_lvl) begin
          sof_n = 1'b1; nxt = ST_FRAME; clr_req = 1'b1;
        end
        ST_FRAME: ;
        ST_EOF: if (cnt == EOF_LAST) begin
          if (!rx_lvl) go_ovl = 1'b1;
          else         go_inter = 1'b1;
        end
        ST_INTER: begin
          if (!rx_lvl) begin
            if (cnt < INTER_LAST) go_ovl = 1'b1;
            else begin
              sof_n = 1'b1; nxt = ST_FRAME; clr_req = 1'b1;
            end
          end else if (cnt == INTER_LAST) begin
            nxt = ST_QUIET; clr_req = 1'b1;
          end
        end
        ST_FLAG: if (cnt == FLAG_LAST) nxt = ST_HOLD;
        ST_HOLD: if (rx_lvl) begin
          nxt = ST_DELIM; cnt_load = 1'b1; load_val = CW'(1);
        end
        ST_DELIM: if (cnt == DELIM_LAST) begin
          if (!rx_lvl) go_ovl = 1'b1;
          else         go_inter = 1'b1;
        end
        default: nxt = ST_QUIET;
      endcase
      if (go_inter) begin
        if (rx_wait && allow) begin
          take = 1'b1; go_ovl = 1'b1;
        end else begin
          nxt = ST_INTER; cnt_load = 1'b1;
        end
      end
      if (go_ovl) begin
        nxt = ST_FLAG; cnt_load = 1'b1; load_val = '0; nxt_ovl = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_QUIET;
      ovl_q     <= 1'b0;
      tx_lvl    <= 1'b1;
      ovl_busy  <= 1'b0;
      bus_quiet <= 1'b1;
      sof_seen  <= 1'b0;
    end else if (bit_stb) begin
      st        <= nxt;
      ovl_q     <= nxt_ovl;
      tx_lvl    <= (nxt != ST_FLAG);
      ovl_busy  <= (nxt == ST_FLAG) || (nxt == ST_HOLD) || (nxt == ST_DELIM && nxt_ovl);
      bus_quiet <= (nxt == ST_QUIET);
      sof_seen  <= sof_n;
    end
  end

  // checker state: length of the current dominant run this node drives
  logic [CW:0] dom_run;
  always_ff @(posedge clk) begin
    if (rst)                  dom_run <= '0;
    else if (bit_stb) begin
      if (tx_lvl)             dom_run <= '0;
      else if (dom_run <= (CW+1)'(FLAG_BITS)) dom_run <= dom_run + 1'b1;
    end
  end

  AST_RESET_OUT: assert property (@(posedge clk)
    $past(rst) && !rst |-> tx_lvl && bus_quiet && !ovl_busy && !sof_seen); // R1
  AST_FLAG_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
    dom_run <= (CW+1)'(FLAG_BITS)); // R2
  AST_DOM_IN_OVL: assert property (@(posedge clk) disable iff (rst)
    !tx_lvl |-> ovl_busy); // R2
  AST_SOF_NOT_OVL: assert property (@(posedge clk) disable iff (rst)
    sof_seen |-> !ovl_busy && !bus_quiet); // R5
  AST_SOF_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    sof_seen && bit_stb |=> !sof_seen); // R5
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable({tx_lvl, ovl_busy, bus_quiet, sof_seen})); // R9
  AST_QUIET_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_quiet && ovl_busy)); // R10
endmodule

// File: tb/test_can_ovl_seq.sv
module test_can_ovl_seq;
  logic clk = 1'b0, rst = 1'b1, bit_stb = 1'b0, rx_lvl = 1'b1;
  logic eof_begin = 1'b0, errdl_begin = 1'b0, rx_wait = 1'b0;
  logic tx_lvl, ovl_busy, bus_quiet, sof_seen;
  int n_run = 0, n_fail = 0;
  int ph = 0, pos = 0, req = 0;
  bit ovl = 0, e_tx = 1, e_ovl = 0, e_quiet = 1, e_sof = 0;

  always #4 clk = ~clk;

  can_ovl_seq i_can_ovl_seq (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .rx_lvl(rx_lvl),
    .eof_begin(eof_begin), .errdl_begin(errdl_begin), .rx_wait(rx_wait),
    .tx_lvl(tx_lvl), .ovl_busy(ovl_busy), .bus_quiet(bus_quiet), .sof_seen(sof_seen)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // expected behaviour per bit, phases: 0 quiet 1 frame 2 eof 3 inter 4 flag 5 hold 6 delim
  task automatic model(input bit rx, input bit eo, input bit ed, input bit bz);
    int np = ph, npos = pos + 1;
    bit nov = ovl, sof = 0, gi = 0, go = 0;
    if (eo) begin np = 2; npos = 0; end
    else if (ed) begin np = 6; npos = 0; nov = 0; end
    else begin
      case (ph)
        0: if (!rx) begin sof = 1; np = 1; req = 0; end
        2: if (pos == 6) begin if (!rx) go = 1; else gi = 1; end
        3: if (!rx) begin
             if (pos < 2) go = 1; else begin sof = 1; np = 1; req = 0; end
           end else if (pos == 2) begin np = 0; req = 0; end
        4: if (pos == 5) np = 5;
        5: if (rx) begin np = 6; npos = 1; end
        6: if (pos == 7) begin if (!rx) go = 1; else gi = 1; end
        default: ;
      endcase
      if (gi) begin
        if (bz && req < 2) begin req++; go = 1; end
        else begin np = 3; npos = 0; end
      end
      if (go) begin np = 4; npos = 0; nov = 1; end
    end
    ph = np; pos = npos; ovl = nov;
    e_tx = (ph != 4); e_quiet = (ph == 0);
    e_ovl = (ph == 4) || (ph == 5) || (ph == 6 && ovl);
    e_sof = sof;
  endtask

  task automatic bitx(input bit rx, input bit eo, input bit ed, input bit bz, input string tag);
    @(negedge clk);
    rx_lvl = rx; eof_begin = eo; errdl_begin = ed; rx_wait = bz; bit_stb = 1'b1;
    model(rx, eo, ed, bz);
    @(negedge clk);
    bit_stb = 1'b0; eof_begin = 1'b0; errdl_begin = 1'b0;
    chk(tag, "tx_lvl", tx_lvl, e_tx);
    chk(tag, "ovl_busy", ovl_busy, e_ovl);
    chk(tag, "bus_quiet", bus_quiet, e_quiet);
    chk(tag, "sof_seen", sof_seen, e_sof);
    rx_lvl = ~rx;  // line activity between strobes must not matter
    for (int k = 0; k < 2; k++) @(negedge clk);
    chk("R9", "hold", {tx_lvl, ovl_busy, bus_quiet, sof_seen} == {e_tx, e_ovl, e_quiet, e_sof}, 1'b1);
  endtask

  task automatic rec(input int n, input string tag);
    for (int k = 0; k < n; k++) bitx(1, 0, 0, 0, tag);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "tx_lvl", tx_lvl, 1'b1);
    chk("R1", "bus_quiet", bus_quiet, 1'b1);
    chk("R1", "ovl_busy", ovl_busy, 1'b0);
    chk("R1", "sof_seen", sof_seen, 1'b0);
    // quiet bus, frame start, clean end of frame, intermission to quiet
    rec(3, "R10");
    bitx(0, 0, 0, 0, "R5");
    rec(4, "R5");
    bitx(1, 1, 0, 0, "R6");
    rec(7, "R6");
    rec(3, "R10");
    // dominant on eof bit 6 ignored, bit 7 triggers
    bitx(0, 0, 0, 0, "R5");
    bitx(1, 1, 0, 0, "R6");
    rec(5, "R6");
    bitx(0, 0, 0, 0, "R6");
    bitx(0, 0, 0, 0, "R6");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 0, "R2");
    for (int k = 0; k < 4; k++) bitx(0, 0, 0, 0, "R3");
    rec(8, "R3");
    // intermission bit 2 dominant, then bit 1 dominant after next delimiter
    bitx(1, 0, 0, 0, "R4");
    bitx(0, 0, 0, 0, "R4");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 0, "R2");
    rec(8, "R3");
    bitx(0, 0, 0, 0, "R4");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 0, "R2");
    rec(7, "R3");
    // dominant on overload delimiter bit 8
    bitx(0, 0, 0, 0, "R7");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 0, "R7");
    rec(8, "R3");
    rec(2, "R4");
    bitx(0, 0, 0, 0, "R5");
    // error delimiter bit 8 dominant
    bitx(1, 0, 1, 0, "R7");
    rec(7, "R7");
    bitx(0, 0, 0, 0, "R7");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 0, "R7");
    rec(8, "R3");
    rec(3, "R10");
    // receiver busy: two overload frames, third request refused
    bitx(0, 0, 0, 0, "R5");
    bitx(1, 1, 0, 1, "R8");
    for (int k = 0; k < 7; k++) bitx(1, 0, 0, 1, "R8");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 1, "R8");
    for (int k = 0; k < 8; k++) bitx(1, 0, 0, 1, "R8");
    for (int k = 0; k < 6; k++) bitx(0, 0, 0, 1, "R8");
    for (int k = 0; k < 8; k++) bitx(1, 0, 0, 1, "R8");
    rec(3, "R8");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      bit rx = ($urandom_range(0, 9) > 2);
      bit eo = ($urandom_range(0, 39) == 0);
      bit ed = ($urandom_range(0, 59) == 0);
      bit bz = ($urandom_range(0, 3) == 0);
      bitx(rx, eo, ed, bz, "RND");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule